// File: doc/BRIEF.md
# Four-Register Serial Line Controller

This block is a single-line asynchronous serial controller. A processor sees it as four 16-bit word registers on a simple register bus with a parameterised base address. Two registers serve the receiver: a status/control word and a data buffer. The other two serve the transmitter, again a status/control word and a data buffer. Characters use an 8N1 frame: one start bit, eight data bits sent least significant bit first, and one stop bit. Each direction samples on its own tick, which runs at 16 times the bit rate.

Two interrupt request outputs, one for receive and one for transmit, each come with their own vector number. The receive vector is the vector base and the transmit vector is the base plus 4. Each further line takes the next 8-byte slot in the address space and the next 8-byte slot in the vector space. The controller can detect an incoming break and, if a strap input allows it, hold a processor-halt request. It can also drive a continuous break on its own line under program control.

Each direction takes its bit rate from its own 4-bit strap input. Software can also program a rate that replaces the strap for the transmitter alone, or for both directions.

Top module: `serial_line_ctrl`

## Requirements
- R1: The four registers decode when bus byte-address bits [17:3] equal BASE_ADDR[17:3]. The word-address bits [1:0] then select the register: 0 is receiver status, 1 is receiver buffer, 2 is transmitter status and 3 is transmitter buffer. An access outside the 8-byte slot reads 0 and its writes change nothing.
- R2: After reset, receiver status reads 0x0000, receiver buffer 0x0000, transmitter status 0x0080 and transmitter buffer 0x0000. After reset, tx_line is 1 and rx_irq, tx_irq and halt_req are 0.
- R3: At the end of a received 8N1 frame (LSB first, sampled at mid-bit), the receiver buffer bits [7:0] hold the byte and receiver status bit 7 (done) is set.
- R4: A read of the receiver buffer clears receiver status bit 7.
- R5: Receiver buffer bit 14 (overrun) is set when a frame completes while done is still set. Bit 13 (framing error) is set when the stop bit is sampled low. Bit 15 is the OR of bits 14 and 13. All three bits describe the most recent frame.
- R6: rx_irq is high while receiver status bits 7 and 6 are both set. tx_irq is high while transmitter status bits 7 (ready) and 6 are both set. rx_vector equals VEC_BASE and tx_vector equals VEC_BASE+4.
- R7: A write to the transmitter buffer while ready is set sends an 8N1 frame of the written bits [7:0], LSB first. Ready stays clear from the next cycle until the stop bit ends. A write to the transmitter buffer while ready is clear is ignored. While the transmitter is idle, tx_line is 1.
- R8: Transmitter status bit 0 set to 1 drives tx_line to 0 from the next cycle. Setting it back to 0 releases the line.
- R9: A break is a received frame whose eight data bits and stop bit are all low. After a break, halt_req is 1 while rx_line stays low and halt_on_break is 1. halt_req returns to 0 within 4 cycles of rx_line going high, and it is never 1 while halt_on_break is 0.
- R10: Rate codes 0 to 15 select 50, 75, 110, 134, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600 and 19200 bit/s. The tick divisor is max(1, floor(CLK_HZ / (16 × rate))), so one bit lasts 16 × divisor clock cycles.
- R11: With transmitter status bit 11 at 0, each direction uses its own strap code. With bit 11 at 1, the transmitter uses the code in bits [15:12]. The receiver also uses that code only when bit 10 is 1 as well; otherwise it keeps its strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | ADDR_W-1 | Byte address bits [ADDR_W-1:1] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational while bus_sel is high |
| rx_line | input | 1 | Serial input, idle high |
| tx_line | output | 1 | Serial output, idle high |
| rx_rate_strap | input | 4 | Receiver rate code strap |
| tx_rate_strap | input | 4 | Transmitter rate code strap |
| halt_on_break | input | 1 | Strap that allows a received break to request a halt |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_vector | output | 9 | Receive vector number |
| tx_vector | output | 9 | Transmit vector number |
| halt_req | output | 1 | Processor halt request |

## Verification
The receiver is given every one of the 256 byte values at the fastest rate and a few bytes at a slow rate. That separates errors in bit order, bit count and sample point from errors that depend on the rate. The transmitter is decoded for 64 spread byte values. Its strap and programmed rates are then swept by sending an all-zero byte and measuring how long the line stays low, which tells each divisor apart. Frames sent back to back unread, frames with a low stop bit, and all-low breaks with the halt strap on and off separate the overrun, framing, break and halt paths from each other.

// File: rtl/slc_pkg.sv
// Shared definitions for the serial line controller.
// Assumes a 16x oversampled bit clock; rates are indexed by a 4-bit code.
package slc_pkg;

    localparam int OVERSAMPLE = 16;

    // Word index of each register inside the 8-byte slot (order is decoded by software).
    typedef enum logic [1:0] {
        REG_RSTAT = 2'd0,
        REG_RDATA = 2'd1,
        REG_TSTAT = 2'd2,
        REG_TDATA = 2'd3
    } slc_reg_e;

    // Bit rate in bit/s selected by a 4-bit code.
    function automatic int rate_hz(input logic [3:0] code);
        case (code)
            4'd0:    return 50;
            4'd1:    return 75;
            4'd2:    return 110;
            4'd3:    return 134;
            4'd4:    return 150;
            4'd5:    return 300;
            4'd6:    return 600;
            4'd7:    return 1200;
            4'd8:    return 1800;
            4'd9:    return 2000;
            4'd10:   return 2400;
            4'd11:   return 3600;
            4'd12:   return 4800;
            4'd13:   return 7200;
            4'd14:   return 9600;
            default: return 19200;
        endcase
    endfunction

    // Clock cycles per oversample tick, never below one.
    function automatic int baud_div(input int clk_hz, input logic [3:0] code);
        int d;
        d = clk_hz / (OVERSAMPLE * rate_hz(code));
        if (d < 1) d = 1;
        return d;
    endfunction

endpackage

// File: rtl/slc_baud.sv
// Oversample tick generator: one-cycle tick every baud_div(CLK_HZ, rate_code) cycles.
// Assumes rate_code may change at any time; the counter is clamped with >= so it recovers.
module slc_baud #(
    parameter int CLK_HZ = 50_000_000,
    parameter int DIV_W  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rate_code,
    output logic       tick
);
    logic [DIV_W-1:0] div_val;
    logic [DIV_W-1:0] cnt;

    assign div_val = DIV_W'(slc_pkg::baud_div(CLK_HZ, rate_code));

    // Count clock cycles and emit a tick at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div_val - DIV_W'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/slc_rx.sv
// 8N1 receiver on a 16x tick. Samples mid-bit, reports each frame with a one-cycle
// valid pulse. After a low stop bit it waits for the line to go high before hunting
// again; a frame of all-low bits marks a break held until the line returns high.
// Assumes line_in is asynchronous (two-flop synchronizer inside).
module slc_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line_in,
    output logic       valid,
    output logic [7:0] data,
    output logic       frame_err,
    output logic       line_break
);
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_e;

    rx_state_e  state;
    logic [1:0] sync;
    logic       line_s;
    logic [3:0] tick_cnt;
    logic [2:0] bit_cnt;
    logic [7:0] shreg;

    assign line_s = sync[1];

    // Bring the serial input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], line_in};
    end

    // Frame state machine: start check, eight data samples, stop sample, hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            tick_cnt   <= '0;
            bit_cnt    <= '0;
            shreg      <= '0;
            valid      <= 1'b0;
            data       <= '0;
            frame_err  <= 1'b0;
            line_break <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (tick && !line_s) begin
                        state    <= RX_START;
                        tick_cnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tick_cnt == 4'd7) begin
                            tick_cnt <= '0;
                            bit_cnt  <= '0;
                            state    <= line_s ? RX_IDLE : RX_DATA;
                        end else begin
                            tick_cnt <= tick_cnt + 4'd1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (tick_cnt == 4'd15) begin
                            tick_cnt <= '0;
                            shreg    <= {line_s, shreg[7:1]};
                            if (bit_cnt == 3'd7) state <= RX_STOP;
                            else                 bit_cnt <= bit_cnt + 3'd1;
                        end else begin
                            tick_cnt <= tick_cnt + 4'd1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (tick_cnt == 4'd15) begin
                            tick_cnt   <= '0;
                            valid      <= 1'b1;
                            data       <= shreg;
                            frame_err  <= !line_s;
                            line_break <= !line_s && (shreg == 8'h00);
                            state      <= line_s ? RX_IDLE : RX_HOLD;
                        end else begin
                            tick_cnt <= tick_cnt + 4'd1;
                        end
                    end
                end
                default: begin
                    if (line_s) begin
                        state      <= RX_IDLE;
                        line_break <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/slc_tx.sv
// 8N1 transmitter on a 16x tick. A start pulse while idle loads a frame; done pulses
// for one cycle when the stop bit has been held for 16 ticks. Starts while busy are ignored.
module slc_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] data,
    output logic       line_bit,
    output logic       done
);
    logic [9:0] shreg;
    logic [3:0] tick_cnt;
    logic [3:0] bit_cnt;
    logic       busy;

    assign line_bit = shreg[0];

    // Load the frame, then shift one bit out every 16 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '1;
            tick_cnt <= '0;
            bit_cnt  <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    shreg    <= {1'b1, data, 1'b0};
                    tick_cnt <= '0;
                    bit_cnt  <= '0;
                    busy     <= 1'b1;
                end
            end else if (tick) begin
                if (tick_cnt == 4'd15) begin
                    tick_cnt <= '0;
                    shreg    <= {1'b1, shreg[9:1]};
                    if (bit_cnt == 4'd9) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end else begin
                    tick_cnt <= tick_cnt + 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/serial_line_ctrl.sv
// Single-line serial controller with four word registers in an 8-byte slot.
// Assumes one-cycle bus_sel strobes; reads are combinational, and the read side
// effect (clearing receiver done) happens at the end of the access cycle.
module serial_line_ctrl #(
    parameter int              ADDR_W    = 18,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(18'o777560),
    parameter logic [8:0]      VEC_BASE  = 9'o060,
    parameter int              CLK_HZ    = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-2:0] bus_word_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              rx_line,
    output logic              tx_line,
    input  logic [3:0]        rx_rate_strap,
    input  logic [3:0]        tx_rate_strap,
    input  logic              halt_on_break,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic [8:0]        rx_vector,
    output logic [8:0]        tx_vector,
    output logic              halt_req
);
    import slc_pkg::*;

    localparam int MAX_DIV = CLK_HZ / (OVERSAMPLE * 50) + 1;
    localparam int DIV_W   = $clog2(MAX_DIV + 1);

    logic       hit;
    logic [1:0] reg_idx;
    logic       wr_rstat, wr_tstat, wr_tdata, rd_rdata;

    logic       rx_done, rx_ie, rx_ovr, rx_ferr;
    logic [7:0] rx_data;
    logic       tx_ready, tx_ie, tx_brk;
    logic [3:0] prog_rate;
    logic       prog_en, prog_both;

    logic       rx_valid, rx_fe, rx_break;
    logic [7:0] rx_byte;
    logic       tx_start, tx_done, tx_bit;
    logic [1:0][3:0] rate_sel;
    logic [1:0] baud_tick;
    logic       unused_wbits;

    assign hit      = bus_sel && (bus_word_addr[ADDR_W-2:2] == BASE_ADDR[ADDR_W-1:3]);
    assign reg_idx  = bus_word_addr[1:0];
    assign wr_rstat = hit && bus_we  && (reg_idx == REG_RSTAT);
    assign wr_tstat = hit && bus_we  && (reg_idx == REG_TSTAT);
    assign wr_tdata = hit && bus_we  && (reg_idx == REG_TDATA);
    assign rd_rdata = hit && !bus_we && (reg_idx == REG_RDATA);
    assign tx_start = wr_tdata && tx_ready;
    assign unused_wbits = ^bus_wdata[9:8];

    // Pick each direction's rate code: index 0 receiver, index 1 transmitter.
    always_comb begin
        rate_sel[1] = prog_en ? prog_rate : tx_rate_strap;
        rate_sel[0] = (prog_en && prog_both) ? prog_rate : rx_rate_strap;
    end

    for (genvar d = 0; d < 2; d++) begin : g_baud
        slc_baud #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_baud (
            .clk       (clk),
            .rst_n     (rst_n),
            .rate_code (rate_sel[d]),
            .tick      (baud_tick[d])
        );
    end

    slc_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick[0]),
        .line_in    (rx_line),
        .valid      (rx_valid),
        .data       (rx_byte),
        .frame_err  (rx_fe),
        .line_break (rx_break)
    );

    slc_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick[1]),
        .start    (tx_start),
        .data     (bus_wdata[7:0]),
        .line_bit (tx_bit),
        .done     (tx_done)
    );

    // Receiver registers: capture frames, flag overrun, clear done on buffer read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_done <= 1'b0;
            rx_ie   <= 1'b0;
            rx_ovr  <= 1'b0;
            rx_ferr <= 1'b0;
            rx_data <= '0;
        end else begin
            if (rx_valid) begin
                rx_done <= 1'b1;
                rx_ovr  <= rx_done && !rd_rdata;
                rx_ferr <= rx_fe;
                rx_data <= rx_byte;
            end else if (rd_rdata) begin
                rx_done <= 1'b0;
            end
            if (wr_rstat) rx_ie <= bus_wdata[6];
        end
    end

    // Transmitter registers: ready handshake, control fields, rate program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ready  <= 1'b1;
            tx_ie     <= 1'b0;
            tx_brk    <= 1'b0;
            prog_rate <= '0;
            prog_en   <= 1'b0;
            prog_both <= 1'b0;
        end else begin
            if (tx_start)     tx_ready <= 1'b0;
            else if (tx_done) tx_ready <= 1'b1;
            if (wr_tstat) begin
                prog_rate <= bus_wdata[15:12];
                prog_en   <= bus_wdata[11];
                prog_both <= bus_wdata[10];
                tx_ie     <= bus_wdata[6];
                tx_brk    <= bus_wdata[0];
            end
        end
    end

    // Read data mux; zero outside the slot.
    always_comb begin
        bus_rdata = 16'h0000;
        if (hit && !bus_we) begin
            case (slc_reg_e'(reg_idx))
                REG_RSTAT: bus_rdata = {8'h00, rx_done, rx_ie, 6'h00};
                REG_RDATA: bus_rdata = {rx_ovr | rx_ferr, rx_ovr, rx_ferr, 5'h00, rx_data};
                REG_TSTAT: bus_rdata = {prog_rate, prog_en, prog_both, 2'b00,
                                        tx_ready, tx_ie, 5'h00, tx_brk};
                default:   bus_rdata = 16'h0000;
            endcase
        end
    end

    assign tx_line   = tx_bit && !tx_brk;
    assign rx_irq    = rx_done && rx_ie;
    assign tx_irq    = tx_ready && tx_ie;
    assign halt_req  = rx_break && halt_on_break;
    assign rx_vector = VEC_BASE;
    assign tx_vector = VEC_BASE + 9'd4;
endmodule

// File: rtl/slc_checker.sv
// Protocol checker for serial_line_ctrl, attached by bind. Decodes the bus on its own
// and relates register accesses to the interrupt, line and halt outputs.
module slc_checker #(
    parameter int                ADDR_W    = 18,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(18'o777560)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-2:0] bus_word_addr,
    input logic              wdata_brk,
    input logic              tx_line,
    input logic              rx_irq,
    input logic              halt_on_break,
    input logic              halt_req,
    input logic              rx_valid,
    input logic              tx_ready,
    input logic              tx_brk
);
    logic in_slot, rbuf_rd, tstat_wr, tbuf_wr;

    assign in_slot  = bus_sel && (bus_word_addr[ADDR_W-2:2] == BASE_ADDR[ADDR_W-1:3]);
    assign rbuf_rd  = in_slot && !bus_we && (bus_word_addr[1:0] == 2'd1);
    assign tstat_wr = in_slot && bus_we  && (bus_word_addr[1:0] == 2'd2);
    assign tbuf_wr  = in_slot && bus_we  && (bus_word_addr[1:0] == 2'd3);

    assert_rbuf_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rbuf_rd && !rx_valid) |=> !rx_irq);

    assert_rx_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_tbuf_write_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tbuf_wr && tx_ready) |=> !tx_ready);

    assert_idle_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_brk) |-> tx_line);

    assert_break_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tstat_wr && wdata_brk) |=> !tx_line);

    assert_halt_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_on_break |-> !halt_req);
endmodule

bind serial_line_ctrl slc_checker #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_slc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_word_addr (bus_word_addr),
    .wdata_brk     (bus_wdata[0]),
    .tx_line       (tx_line),
    .rx_irq        (rx_irq),
    .halt_on_break (halt_on_break),
    .halt_req      (halt_req),
    .rx_valid      (rx_valid),
    .tx_ready      (tx_ready),
    .tx_brk        (tx_brk)
);

// File: tb/serial_line_ctrl_bench.sv
// Self-checking bench: second extra line slot, slow clock constant for short bit times.
module serial_line_ctrl_bench;
    localparam int          CLK_HZ = 307200;
    localparam logic [17:0] BASE   = 18'o776510;
    localparam logic [8:0]  VEC    = 9'o310;
    localparam logic [16:0] BASE_W = BASE[17:1];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [16:0] bus_word_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_line = 1'b1;
    logic        tx_line;
    logic [3:0]  rx_rate_strap = 4'd15, tx_rate_strap = 4'd15;
    logic        halt_on_break = 1'b0;
    logic        rx_irq, tx_irq, halt_req;
    logic [8:0]  rx_vector, tx_vector;

    int checks = 0;
    int fails  = 0;

    serial_line_ctrl #(.ADDR_W(18), .BASE_ADDR(BASE), .VEC_BASE(VEC), .CLK_HZ(CLK_HZ))
    u_serial_line_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_word_addr(bus_word_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_line(rx_line), .tx_line(tx_line), .rx_rate_strap(rx_rate_strap),
        .tx_rate_strap(tx_rate_strap), .halt_on_break(halt_on_break),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_vector(rx_vector),
        .tx_vector(tx_vector), .halt_req(halt_req)
    );

    always #2 clk = ~clk;

    function automatic int exp_div(input int code);
        int rates [16] = '{50, 75, 110, 134, 150, 300, 600, 1200,
                           1800, 2000, 2400, 3600, 4800, 7200, 9600, 19200};
        int d;
        d = CLK_HZ / (16 * rates[code]);
        return (d < 1) ? 1 : d;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input int off, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_word_addr = BASE_W + 17'(off); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int off, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_word_addr = BASE_W + 17'(off);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input bit stop_v, input int p);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (p) @(negedge clk);
        end
        rx_line = stop_v;
        repeat (p) @(negedge clk);
        rx_line = 1'b1;
        repeat (p) @(negedge clk);
    endtask

    task automatic catch_tx(input int p, output logic [7:0] b, output bit ok);
        int t = 0;
        b = '0;
        while (tx_line !== 1'b0 && t < 40 * p) begin
            @(negedge clk);
            t++;
        end
        ok = (tx_line === 1'b0);
        repeat (p / 2) @(negedge clk);
        if (tx_line !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (p) @(negedge clk);
            b[i] = tx_line;
        end
        repeat (p) @(negedge clk);
        if (tx_line !== 1'b1) ok = 1'b0;
    endtask

    task automatic wait_ready(input int limit);
        logic [15:0] s;
        int t = 0;
        rd(2, s);
        while (!s[7] && t < limit) begin
            rd(2, s);
            t++;
        end
    endtask

    // Low time of an all-zero frame: start plus eight data bits.
    task automatic low_width(output int w);
        int t = 0;
        w = 0;
        while (tx_line !== 1'b0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        while (tx_line === 1'b0 && w < 200000) begin
            @(negedge clk);
            w++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  b;
        bit          ok;
        int          w, dv, lows;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(0, v); chk(v == 16'h0000, "R2 rstat", v, 16'h0000);
        rd(1, v); chk(v == 16'h0000, "R2 rbuf", v, 16'h0000);
        rd(2, v); chk(v == 16'h0080, "R2 tstat", v, 16'h0080);
        rd(3, v); chk(v == 16'h0000, "R2 tbuf", v, 16'h0000);
        chk({tx_line, rx_irq, tx_irq, halt_req} == 4'b1000, "R2 outputs",
            {tx_line, rx_irq, tx_irq, halt_req}, 4'b1000);

        // R6 vectors
        chk(rx_vector == 9'o310, "R6 rx_vector", rx_vector, 9'o310);
        chk(tx_vector == 9'o314, "R6 tx_vector", tx_vector, 9'o314);

        // R1 outside the slot: next slot reads zero, writes there are ignored
        wr(4, 16'h0041);
        rd(2, v); chk(v == 16'h0080, "R1 write outside slot", v, 16'h0080);
        rd(6, v); chk(v == 16'h0000, "R1 read outside slot", v, 16'h0000);
        wr(-4, 16'h0040);
        rd(0, v); chk(v == 16'h0000, "R1 write below slot", v, 16'h0000);

        // R3 R4 R6 exhaustive receive sweep at divisor 1
        wr(0, 16'h0040);
        for (int i = 0; i < 256; i++) begin
            send_rx(8'(i), 1'b1, 16 * exp_div(15));
            chk(rx_irq === 1'b1, "R6 rx_irq after frame", rx_irq, 1);
            rd(1, v);
            chk(v == {8'h00, 8'(i)}, "R3 rbuf byte", v, i);
            rd(0, v);
            chk(v == 16'h0040, "R4 done cleared by read", v, 16'h0040);
        end

        // R3 at a slow strap rate
        rx_rate_strap = 4'd10;
        for (int i = 0; i < 4; i++) begin
            send_rx(8'(8'h3C ^ (i * 8'h51)), 1'b1, 16 * exp_div(10));
            rd(1, v);
            chk(v == {8'h00, 8'(8'h3C ^ (i * 8'h51))}, "R3 slow rate byte", v,
                8'h3C ^ (i * 8'h51));
        end
        rx_rate_strap = 4'd15;

        // R5 overrun, then a clean frame clears the error bits
        send_rx(8'h11, 1'b1, 16);
        send_rx(8'h22, 1'b1, 16);
        rd(1, v); chk(v == 16'hC022, "R5 overrun", v, 16'hC022);
        send_rx(8'h33, 1'b1, 16);
        rd(1, v); chk(v == 16'h0033, "R5 errors follow latest frame", v, 16'h0033);

        // R5 framing error, no halt for a non-zero byte
        halt_on_break = 1'b1;
        send_rx(8'h5A, 1'b0, 16);
        chk(halt_req === 1'b0, "R9 no halt on framing error", halt_req, 0);
        rd(1, v); chk(v == 16'hA05A, "R5 framing error", v, 16'hA05A);

        // R9 break with halt allowed
        @(negedge clk); rx_line = 1'b0;
        repeat (12 * 16) @(negedge clk);
        chk(halt_req === 1'b1, "R9 halt during break", halt_req, 1);
        rd(1, v); chk(v == 16'hA000, "R9 break frame", v, 16'hA000);
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
        chk(halt_req === 1'b0, "R9 halt released", halt_req, 0);
        repeat (32) @(negedge clk);

        // R9 break with halt strap off
        halt_on_break = 1'b0;
        @(negedge clk); rx_line = 1'b0;
        repeat (12 * 16) @(negedge clk);
        chk(halt_req === 1'b0, "R9 halt blocked by strap", halt_req, 0);
        rd(1, v); chk(v == 16'hA000, "R9 break frame strap off", v, 16'hA000);
        rx_line = 1'b1;
        repeat (32) @(negedge clk);

        // R8 send break
        wr(2, 16'h0001);
        chk(tx_line === 1'b0, "R8 break drives low", tx_line, 0);
        rd(2, v); chk(v == 16'h0081, "R8 tstat readback", v, 16'h0081);
        wr(2, 16'h0000);
        chk(tx_line === 1'b1, "R8 break released", tx_line, 1);

        // R7 R6 transmit sweep at divisor 1
        wr(2, 16'h0040);
        chk(tx_irq === 1'b1, "R6 tx_irq when ready", tx_irq, 1);
        for (int i = 0; i < 64; i++) begin
            wr(3, 16'(8'(i * 37 + 5)));
            chk(tx_irq === 1'b0, "R7 ready cleared after write", tx_irq, 0);
            catch_tx(16 * exp_div(15), b, ok);
            chk(ok && b == 8'(i * 37 + 5), "R7 transmitted byte", b, 8'(i * 37 + 5));
            repeat (16) @(negedge clk);
            chk(tx_irq === 1'b1, "R7 ready after stop bit", tx_irq, 1);
        end

        // R7 write while busy is ignored
        wr(3, 16'h003C);
        wr(3, 16'h00FF);
        catch_tx(16, b, ok);
        chk(ok && b == 8'h3C, "R7 busy write ignored", b, 8'h3C);
        lows = 0;
        repeat (48) begin
            @(negedge clk);
            if (tx_line !== 1'b1) lows++;
        end
        chk(lows == 0, "R7 no second frame", lows, 0);

        // R10 R11 programmed transmit rate sweep, measured by low time of 0x00
        for (int c = 5; c < 16; c++) begin
            wr(2, 16'(c << 12) | 16'h0800);
            wr(3, 16'h0000);
            low_width(w);
            dv = exp_div(c);
            chk(w >= 144 * dv - dv && w <= 144 * dv + 1, "R10 tx divisor", w, 144 * dv);
            wait_ready(40 * dv);
        end

        // R11 strap path for the transmitter when programming is off
        wr(2, 16'h0000);
        tx_rate_strap = 4'd13;
        wr(3, 16'h0000);
        low_width(w);
        dv = exp_div(13);
        chk(w >= 144 * dv - dv && w <= 144 * dv + 1, "R11 tx strap rate", w, 144 * dv);
        wait_ready(40 * dv);
        tx_rate_strap = 4'd15;

        // R11 transmitter-only program keeps receiver on its strap
        wr(2, 16'hC800);
        wr(3, 16'h00C3);
        catch_tx(16 * exp_div(12), b, ok);
        chk(ok && b == 8'hC3, "R11 tx programmed rate", b, 8'hC3);
        wait_ready(200);
        send_rx(8'h96, 1'b1, 16 * exp_div(15));
        rd(1, v); chk(v == 16'h0096, "R11 rx keeps strap", v, 16'h0096);

        // R11 program applied to both directions
        wr(2, 16'hCC00);
        send_rx(8'h69, 1'b1, 16 * exp_div(12));
        rd(1, v); chk(v == 16'h0069, "R11 rx programmed rate", v, 16'h0069);
        rd(2, v); chk(v == 16'hCC80, "R11 tstat readback", v, 16'hCC80);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule